// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins with a word-addressed register interface. Software sets the direction of each pin and drives output data. It reads back the synchronised input levels, and it has every pin watched for interrupt events. Output data and interrupt masks change only through dedicated set and clear registers. Two agents working on different bits therefore never need a read-modify-write.

Each pin first passes through a two-stage synchroniser. A per-pin trigger selection then turns the synchronised level into an event. Three configuration bits make the selection: edge or level, single or dual edge, and active polarity. Events latch into a pending register, which software acknowledges by writing ones. The pending bits, gated by the per-pin enables, are OR-reduced into a single parent interrupt.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, direction, output data, interrupt enables and pending are all zero, every pin is set to edge mode (offset 9 reads all ones) with positive polarity (offset 11 reads all ones) and single edge (offset 10 reads zero), and irq_out is low.
- R2: A write to offset 2 sets the output bits where the data has a 1, and a write to offset 3 clears them. Zero bits leave their pins unchanged. The result appears on pin_out one cycle after the write and reads back at offset 4.
- R3: Offset 1 is a read/write direction register, where 1 drives the pin. Its value appears on pin_oe and reads back unchanged.
- R4: Offset 0 returns the pin levels after a two-cycle synchroniser. A change on pin_in is not visible after one clock edge and is visible after two.
- R5: A write to offset 5 enables interrupts for the pins written with 1, a write to offset 6 disables them, and offset 7 reads the current enables.
- R6: In edge mode (offset 9 bit = 1) with single edge, a pin with polarity bit 1 latches pending on a rising level and a pin with polarity bit 0 latches on a falling level. The opposite transition does not latch. The pending bit reads set after the third clock edge following the pin change, and not after the second.
- R7: When the both-edges bit (offset 10) is set for an edge-mode pin, both transitions latch pending, whatever the polarity bit says.
- R8: In level mode (offset 9 bit = 0), pending is set on every cycle the active level (high for polarity 1, low for 0) is present. An acknowledge therefore only clears the bit once the input is inactive.
- R9: Offset 8 reads all pending bits at once. Writing 1 to a bit clears it, and writing 0 leaves it.
- R10: If an event and an acknowledge for the same pin occur in the same cycle, the pending bit stays set.
- R11: irq_out is high exactly when some pin is both pending and enabled.
- R12: Reads of the write-only offsets 2, 3, 5, 6 and of unmapped offsets 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin |
| irq_out | output | 1 | Combined parent interrupt |

## Verification
A bad configuration or mask register shows on pin_out, pin_oe or irq_out on the very next cycle. A reference model compares those ports on every cycle, so such an error surfaces at once. A fault in the synchroniser or event logic shows only through pending and irq_out, three edges after the pin change. The directed cases therefore sample both one cycle early and exactly on time. The pending register is the only place where history builds up. Same-cycle acknowledge and event collisions, and level pins that refire after an acknowledge, are forced in directed tests and also occur under random register traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_IN    = 4'd0,
    RA_DIR   = 4'd1,
    RA_OSET  = 4'd2,
    RA_OCLR  = 4'd3,
    RA_ODATA = 4'd4,
    RA_ESET  = 4'd5,
    RA_ECLR  = 4'd6,
    RA_EMASK = 4'd7,
    RA_PEND  = 4'd8,
    RA_TEDGE = 4'd9,
    RA_TBOTH = 4'd10,
    RA_TPOL  = 4'd11
  } reg_addr_e;

  // Event decision for one pin from current and previous synchronised level.
  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic is_edge, input logic both,
                                     input logic pos);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (is_edge) return both ? (rise | fall) : (pos ? rise : fall);
    return pos ? cur : ~cur;
  endfunction

  // Atomic bit update: ones in set force 1, ones in clr force 0.
  function automatic logic [31:0] set_clr(input logic [31:0] cur,
                                          input logic [31:0] set,
                                          input logic [31:0] clr);
    return (cur | set) & ~clr;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] cfg_edge,
  input  logic [W-1:0] cfg_both,
  input  logic [W-1:0] cfg_pos,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = pin_event(lvl[i], prev_q[i], cfg_edge[i], cfg_both[i], cfg_pos[i]);
  end
endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  input  logic [W-1:0] en,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack) | evt;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & en);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((pend_q & $past(ack & ~evt)) == '0)); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt))); // R10
  AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [REG_AW-1:0]       bus_addr,
  input  logic [NPINS-1:0]        bus_wdata,
  output logic [NPINS-1:0]        bus_rdata,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic                    irq_out
);
  localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

  logic [NPINS-1:0] dir_q, out_q, ie_q, tedge_q, tboth_q, tpol_q;
  logic [NPINS-1:0] sync_lvl, evt, pend, ack;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_lvl)
  );

  gpio_trigger #(.W(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
    .cfg_edge(tedge_q), .cfg_both(tboth_q), .cfg_pos(tpol_q), .evt(evt)
  );

  assign ack = (bus_we && bus_addr == RA_PEND) ? bus_wdata : '0;

  gpio_pending #(.W(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ack(ack), .en(ie_q),
    .pend(pend), .irq(irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ie_q    <= '0;
      tedge_q <= ALL_ONES;
      tboth_q <= '0;
      tpol_q  <= ALL_ONES;
    end else if (bus_we) begin
      case (bus_addr)
        RA_DIR:   dir_q   <= bus_wdata;
        RA_OSET:  out_q   <= NPINS'(set_clr(32'(out_q), 32'(bus_wdata), 32'd0));
        RA_OCLR:  out_q   <= NPINS'(set_clr(32'(out_q), 32'd0, 32'(bus_wdata)));
        RA_ESET:  ie_q    <= NPINS'(set_clr(32'(ie_q), 32'(bus_wdata), 32'd0));
        RA_ECLR:  ie_q    <= NPINS'(set_clr(32'(ie_q), 32'd0, 32'(bus_wdata)));
        RA_TEDGE: tedge_q <= bus_wdata;
        RA_TBOTH: tboth_q <= bus_wdata;
        RA_TPOL:  tpol_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      RA_IN:    bus_rdata = sync_lvl;
      RA_DIR:   bus_rdata = dir_q;
      RA_ODATA: bus_rdata = out_q;
      RA_EMASK: bus_rdata = ie_q;
      RA_PEND:  bus_rdata = pend;
      RA_TEDGE: bus_rdata = tedge_q;
      RA_TBOTH: bus_rdata = tboth_q;
      RA_TPOL:  bus_rdata = tpol_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  AST_OUT_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_OSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_OUT_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_OCLR) |=> ((pin_out & $past(bus_wdata)) == '0)); // R2
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == RA_OSET || bus_addr == RA_OCLR)) |=> $stable(pin_out)); // R2
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ie_q != '0)); // R11
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend != '0)); // R11
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // Reference model, written from the requirements
  logic [31:0] m_s1, m_s2, m_sp, m_dir, m_out, m_ie, m_pend, m_te, m_tb, m_tp;

  function automatic logic [31:0] b_evt(input logic [31:0] cur, prev, te, tb, tp);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (!te[i])      r[i] = tp[i] ? cur[i] : !cur[i];
      else if (tb[i])  r[i] = cur[i] != prev[i];
      else if (tp[i])  r[i] = cur[i] && !prev[i];
      else             r[i] = !cur[i] && prev[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_s2;
      4'd1: return m_dir;
      4'd4: return m_out;
      4'd7: return m_ie;
      4'd8: return m_pend;
      4'd9: return m_te;
      4'd10: return m_tb;
      4'd11: return m_tp;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R4";
      4'd1: return "R3";
      4'd4: return "R2";
      4'd7: return "R5";
      4'd8: return "R9";
      4'd9, 4'd10, 4'd11: return "R1";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_sp <= '0; m_dir <= '0; m_out <= '0;
      m_ie <= '0; m_pend <= '0; m_te <= '1; m_tb <= '0; m_tp <= '1;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_sp <= m_s2;
      m_pend <= (m_pend & ~((bus_we && bus_addr == 4'd8) ? bus_wdata : 32'd0))
                | b_evt(m_s2, m_sp, m_te, m_tb, m_tp);
      if (bus_we) begin
        case (bus_addr)
          4'd1: m_dir <= bus_wdata;
          4'd2: m_out <= m_out | bus_wdata;
          4'd3: m_out <= m_out & ~bus_wdata;
          4'd5: m_ie <= m_ie | bus_wdata;
          4'd6: m_ie <= m_ie & ~bus_wdata;
          4'd9: m_te <= bus_wdata;
          4'd10: m_tb <= bus_wdata;
          4'd11: m_tp <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Port-level comparison with the model on every cycle
  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      chk("R2", pin_out, m_out);
      chk("R3", pin_oe, m_dir);
      chk("R11", {31'd0, irq_out}, {31'd0, |(m_pend & m_ie)});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_we = 1'b0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick(1);
    // R1 reset state
    rdchk("R1", 4'd1, 32'd0);
    rdchk("R1", 4'd4, 32'd0);
    rdchk("R1", 4'd7, 32'd0);
    rdchk("R1", 4'd8, 32'd0);
    rdchk("R1", 4'd9, 32'hFFFF_FFFF);
    rdchk("R1", 4'd10, 32'd0);
    rdchk("R1", 4'd11, 32'hFFFF_FFFF);
    chk("R1", {31'd0, irq_out}, 32'd0);
    // R12 write-only and unmapped reads
    rdchk("R12", 4'd2, 32'd0);
    rdchk("R12", 4'd3, 32'd0);
    rdchk("R12", 4'd5, 32'd0);
    rdchk("R12", 4'd6, 32'd0);
    rdchk("R12", 4'd15, 32'd0);
    tick(1);
    // R2 set and clear of output data
    wr(4'd2, 32'h0000_00F0);
    chk("R2", pin_out, 32'h0000_00F0);
    wr(4'd2, 32'h0000_0003);
    chk("R2", pin_out, 32'h0000_00F3);
    wr(4'd3, 32'h0000_0030);
    chk("R2", pin_out, 32'h0000_00C3);
    rdchk("R2", 4'd4, 32'h0000_00C3);
    tick(1);
    // R3 direction
    wr(4'd1, 32'hA5A5_0000);
    chk("R3", pin_oe, 32'hA5A5_0000);
    rdchk("R3", 4'd1, 32'hA5A5_0000);
    tick(1);
    // R4 synchroniser latency, R6 rising-edge pending latency
    pin_in = 32'h1234_5678;
    tick(1);
    rdchk("R4", 4'd0, 32'd0);
    tick(1);
    rdchk("R4", 4'd0, 32'h1234_5678);
    rdchk("R6", 4'd8, 32'd0);
    tick(1);
    rdchk("R6", 4'd8, 32'h1234_5678);
    tick(1);
    // R9 acknowledge: zero bits keep, one bits clear
    wr(4'd8, 32'h0000_FFFF);
    rdchk("R9", 4'd8, 32'h1234_0000);
    wr(4'd8, 32'hFFFF_0000);
    rdchk("R9", 4'd8, 32'd0);
    tick(1);
    // R5 enables
    wr(4'd5, 32'h0000_000F);
    wr(4'd5, 32'h0000_0100);
    wr(4'd6, 32'h0000_0003);
    rdchk("R5", 4'd7, 32'h0000_010C);
    chk("R11", {31'd0, irq_out}, 32'd0);
    tick(1);
    // R6 falling edge on pin 3 with negative polarity
    wr(4'd11, 32'hFFFF_FFF7);
    pin_in = 32'h1234_5670;
    tick(2);
    rdchk("R6", 4'd8, 32'd0);
    chk("R11", {31'd0, irq_out}, 32'd0);
    tick(1);
    rdchk("R6", 4'd8, 32'h0000_0008);
    chk("R11", {31'd0, irq_out}, 32'd1);
    tick(1);
    wr(4'd8, 32'h0000_0008);
    chk("R11", {31'd0, irq_out}, 32'd0);
    // R7 both edges on pin 8
    wr(4'd10, 32'h0000_0100);
    pin_in = pin_in | 32'h0000_0100;
    tick(3);
    rdchk("R7", 4'd8, 32'h0000_0100);
    tick(1);
    wr(4'd8, 32'h0000_0100);
    pin_in = pin_in & ~32'h0000_0100;
    tick(3);
    rdchk("R7", 4'd8, 32'h0000_0100);
    tick(1);
    wr(4'd8, 32'h0000_0100);
    // R8 level-high on pin 2
    wr(4'd9, 32'hFFFF_FFFB);
    pin_in = pin_in | 32'h0000_0004;
    tick(3);
    rdchk("R8", 4'd8, 32'h0000_0004);
    tick(1);
    wr(4'd8, 32'h0000_0004);
    rdchk("R8", 4'd8, 32'h0000_0004);
    tick(1);
    pin_in = pin_in & ~32'h0000_0004;
    tick(3);
    wr(4'd8, 32'h0000_0004);
    rdchk("R8", 4'd8, 32'd0);
    tick(2);
    rdchk("R8", 4'd8, 32'd0);
    tick(1);
    // R10 event and acknowledge in the same cycle (pin 3, falling)
    pin_in = pin_in | 32'h0000_0008;
    tick(3);
    rdchk("R6", 4'd8, 32'd0);
    tick(1);
    pin_in = pin_in & ~32'h0000_0008;
    tick(3);
    rdchk("R10", 4'd8, 32'h0000_0008);
    tick(1);
    pin_in = pin_in | 32'h0000_0008;
    tick(3);
    pin_in = pin_in & ~32'h0000_0008;
    tick(2);
    wr(4'd8, 32'h0000_0008);
    rdchk("R10", 4'd8, 32'h0000_0008);
    tick(1);
    wr(4'd8, 32'h0000_0008);
    rdchk("R10", 4'd8, 32'd0);
    tick(1);
    // Random register traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 4 == 0) pin_in = $urandom;
      if ($urandom % 3 == 0) begin
        bus_we = 1'b1;
        bus_addr = 4'(1 + $urandom % 11);
        bus_wdata = $urandom;
      end else begin
        bus_we = 1'b0;
        bus_addr = 4'($urandom % 16);
        #1 chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      end
      @(negedge clk);
    end
    bus_we = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule